// File: doc/BRIEF.md
# Interrupt Dispatch Sequencer

This block services pending interrupts for a 16-bit emulated processor. It keeps a pending-interrupts register whose most significant bit acts as an "interrupts off" flag. Other logic can raise channel bits in that register at any time through a set input. When the processor asks for a reschedule, the sequencer first decides whether there is anything to do. If there is, it merges the waiting word held in memory into the register and masks the result with an active-channel word, which is also read from memory.

If no active channel is pending, the merged bits are written back to the waiting word and execution resumes. Otherwise the sequencer saves the current PC to memory. It then scans the candidates serially from bit 0 upward, one bit per cycle, and clears the chosen channel. It fetches that channel's vector and writes the remaining pending bits back to the waiting word. It disables further interrupts and hands the vector out as the restart PC with a one-cycle strobe.

All memory traffic goes through a single request/acknowledge word port.

Top module: `irq_dispatch_seq`

## Requirements
- R1: After synchronous reset, the pending register reads zero, busy, start and resume are low, and no memory request is made.
- R2: A reschedule request while the pending register is zero or has bit 15 set produces a resume pulse, makes no memory access, and leaves the pending register unchanged.
- R3: Otherwise the block reads octal address 452 (waiting word) and then octal address 453 (active mask). It ORs the waiting word into the pending register and ANDs the merged value with the mask.
- R4: If that AND is zero, the block writes the merged value to octal 452 and leaves the pending register at zero. It then pulses resume, after three memory accesses in total.
- R5: If the AND is nonzero, the block restores the pending register to the merged value and writes the PC that was present at the request to octal address 500.
- R6: The chosen channel k is the lowest set bit of the AND result. The vector is read from octal 501 + k. Each step up in k adds exactly one cycle to the dispatch.
- R7: On dispatch, the block writes the merged value with bit k cleared to octal 452, and the pending register then reads 16'h8000.
- R8: A dispatch ends with start high for exactly one cycle and new_pc equal to the fetched vector. The access order is read 452, read 453, write 500, read 501+k, write 452.
- R9: While mem_req is high and mem_ack is low, mem_addr, mem_we and mem_wdata stay stable. Read data is taken only in the cycle mem_ack is high.
- R10: Bits on set_req are ORed into the pending register in every cycle in which the sequencer does not itself write that register.
- R11: busy goes high the cycle after an accepted request and stays high until resume or start is pulsed. It drops the following cycle, and resume and start are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resched_req | input | 1 | Reschedule request, sampled while idle |
| set_req | input | 16 | Channel bits to OR into the pending register |
| cur_pc | input | 16 | Current PC, captured when a request is accepted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle access completion |
| busy | output | 1 | Sequence in progress |
| resume | output | 1 | One-cycle pulse: continue without dispatch |
| start | output | 1 | One-cycle pulse: restart at new_pc |
| new_pc | output | 16 | Vector fetched for the dispatched channel |
| pend | output | 16 | Pending-interrupts register |

## Verification
The bench builds the block at its default 16-bit width and the default memory addresses, with a one-cycle-latency memory model. At this width the dispatch sweep can cover every channel position from 0 to 14 directly, plus channel 15 reached through the waiting word. It can therefore measure the one-cycle-per-position cost of the serial scan against channel 0. Masked-off low channels, both false-alarm conditions, a zero-result park and a request made while interrupts are disabled are run as separate cases. The full access order and the written memory words are checked for each case.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RESUME,
        ST_RD_WAIT,
        ST_RD_MASK,
        ST_DECIDE,
        ST_PARK,
        ST_SAVE_PC,
        ST_SCAN,
        ST_FETCH_VEC,
        ST_WR_DIS,
        ST_START
    } seq_state_e;

    typedef enum logic [1:0] {
        AS_WAITING,
        AS_ACTIVE,
        AS_PCSAVE,
        AS_VECTOR
    } addr_sel_e;

    typedef enum logic [0:0] {
        DS_PC,
        DS_HOLD
    } data_sel_e;

    typedef struct packed {
        logic      req;
        logic      we;
        addr_sel_e asel;
        data_sel_e dsel;
    } mem_cmd_t;

    // Memory command issued while the sequencer sits in a given state.
    function automatic mem_cmd_t cmd_for_state(input seq_state_e s);
        mem_cmd_t c;
        c.req  = 1'b0;
        c.we   = 1'b0;
        c.asel = AS_WAITING;
        c.dsel = DS_HOLD;
        case (s)
            ST_RD_WAIT: begin
                c.req = 1'b1;
            end
            ST_RD_MASK: begin
                c.req  = 1'b1;
                c.asel = AS_ACTIVE;
            end
            ST_PARK: begin
                c.req = 1'b1;
                c.we  = 1'b1;
            end
            ST_SAVE_PC: begin
                c.req  = 1'b1;
                c.we   = 1'b1;
                c.asel = AS_PCSAVE;
                c.dsel = DS_PC;
            end
            ST_FETCH_VEC: begin
                c.req  = 1'b1;
                c.asel = AS_VECTOR;
            end
            ST_WR_DIS: begin
                c.req = 1'b1;
                c.we  = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_bits,
    input  logic         seq_we,
    input  logic [W-1:0] seq_val,
    output logic [W-1:0] pend
);
    // Sequencer writes take precedence; external set bits merge otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (seq_we) begin
            pend <= seq_val;
        end else begin
            pend <= pend | set_bits;
        end
    end
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
    parameter int W    = 16,
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [W-1:0]    cand,
    input  logic            step,
    output logic            hit,
    output logic [CH_W-1:0] chan,
    output logic [W-1:0]    probe
);
    logic [W-1:0] cand_q;
    logic [W-1:0] probe_q;
    logic [CH_W-1:0] chan_q;

    assign hit   = |(cand_q & probe_q);
    assign chan  = chan_q;
    assign probe = probe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q  <= '0;
            probe_q <= '0;
            chan_q  <= '0;
        end else if (load) begin
            cand_q  <= cand;
            probe_q <= W'(1);
            chan_q  <= '0;
        end else if (step && !hit && !probe_q[W-1]) begin
            probe_q <= probe_q << 1;
            chan_q  <= chan_q + CH_W'(1);
        end
    end
endmodule

// File: rtl/irq_mem_if.sv
module irq_mem_if
    import irq_seq_pkg::*;
#(
    parameter int          W         = 16,
    parameter int          CH_W      = 4,
    parameter logic [W-1:0] WAIT_ADDR = W'(9'o452),
    parameter logic [W-1:0] MASK_ADDR = W'(9'o453),
    parameter logic [W-1:0] SAVE_ADDR = W'(9'o500),
    parameter logic [W-1:0] VEC_BASE  = W'(9'o501)
) (
    input  mem_cmd_t        cmd,
    input  logic [W-1:0]    pc,
    input  logic [W-1:0]    hold,
    input  logic [CH_W-1:0] chan,
    output logic            mem_req,
    output logic            mem_we,
    output logic [W-1:0]    mem_addr,
    output logic [W-1:0]    mem_wdata
);
    always_comb begin
        mem_req = cmd.req;
        mem_we  = cmd.we;
        case (cmd.asel)
            AS_WAITING: mem_addr = WAIT_ADDR;
            AS_ACTIVE:  mem_addr = MASK_ADDR;
            AS_PCSAVE:  mem_addr = SAVE_ADDR;
            default:    mem_addr = VEC_BASE + W'(chan);
        endcase
        mem_wdata = (cmd.dsel == DS_PC) ? pc : hold;
    end
endmodule

// File: rtl/irq_dispatch_seq.sv
module irq_dispatch_seq
    import irq_seq_pkg::*;
#(
    parameter int          W         = 16,
    parameter logic [W-1:0] WAIT_ADDR = W'(9'o452),
    parameter logic [W-1:0] MASK_ADDR = W'(9'o453),
    parameter logic [W-1:0] SAVE_ADDR = W'(9'o500),
    parameter logic [W-1:0] VEC_BASE  = W'(9'o501)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         resched_req,
    input  logic [W-1:0] set_req,
    input  logic [W-1:0] cur_pc,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_ack,
    output logic         busy,
    output logic         resume,
    output logic         start,
    output logic [W-1:0] new_pc,
    output logic [W-1:0] pend
);
    localparam int CH_W = $clog2(W);
    localparam logic [W-1:0] INTS_OFF = {1'b1, {(W-1){1'b0}}};

    seq_state_e state_q, state_d;
    logic [W-1:0] pc_q;
    logic [W-1:0] hold_q;
    logic [W-1:0] vec_q;

    logic         pend_we;
    logic [W-1:0] pend_val;
    logic         hold_we;
    logic [W-1:0] hold_val;

    logic            scan_load;
    logic            scan_step;
    logic            scan_hit;
    logic [CH_W-1:0] scan_chan;
    logic [W-1:0]    scan_probe;

    mem_cmd_t cmd;

    // Next-state and register-update decisions.
    always_comb begin
        state_d   = state_q;
        pend_we   = 1'b0;
        pend_val  = pend;
        hold_we   = 1'b0;
        hold_val  = pend;
        scan_load = 1'b0;
        scan_step = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (resched_req) begin
                    if (pend == '0 || pend[W-1]) state_d = ST_RESUME;
                    else                         state_d = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (mem_ack) begin
                    pend_we  = 1'b1;
                    pend_val = pend | mem_rdata;
                    state_d  = ST_RD_MASK;
                end
            end
            ST_RD_MASK: begin
                if (mem_ack) begin
                    hold_we  = 1'b1;
                    hold_val = pend;
                    pend_we  = 1'b1;
                    pend_val = pend & mem_rdata;
                    state_d  = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                if (pend == '0) begin
                    state_d = ST_PARK;
                end else begin
                    pend_we   = 1'b1;
                    pend_val  = hold_q;
                    scan_load = 1'b1;
                    state_d   = ST_SAVE_PC;
                end
            end
            ST_PARK: begin
                if (mem_ack) state_d = ST_RESUME;
            end
            ST_SAVE_PC: begin
                if (mem_ack) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                scan_step = 1'b1;
                if (scan_hit) begin
                    pend_we  = 1'b1;
                    pend_val = pend & ~scan_probe;
                    hold_we  = 1'b1;
                    hold_val = hold_q & ~scan_probe;
                    state_d  = ST_FETCH_VEC;
                end
            end
            ST_FETCH_VEC: begin
                if (mem_ack) state_d = ST_WR_DIS;
            end
            ST_WR_DIS: begin
                if (mem_ack) begin
                    pend_we  = 1'b1;
                    pend_val = INTS_OFF;
                    state_d  = ST_START;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            hold_q  <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && resched_req) pc_q <= cur_pc;
            if (hold_we) hold_q <= hold_val;
            if (state_q == ST_FETCH_VEC && mem_ack) vec_q <= mem_rdata;
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign resume = (state_q == ST_RESUME);
    assign start  = (state_q == ST_START);
    assign new_pc = vec_q;
    assign cmd    = cmd_for_state(state_q);

    irq_pend_reg #(.W(W)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .set_bits (set_req),
        .seq_we   (pend_we),
        .seq_val  (pend_val),
        .pend     (pend)
    );

    irq_prio_scan #(.W(W), .CH_W(CH_W)) u_scan (
        .clk   (clk),
        .rst   (rst),
        .load  (scan_load),
        .cand  (pend),
        .step  (scan_step),
        .hit   (scan_hit),
        .chan  (scan_chan),
        .probe (scan_probe)
    );

    irq_mem_if #(
        .W(W), .CH_W(CH_W), .WAIT_ADDR(WAIT_ADDR), .MASK_ADDR(MASK_ADDR),
        .SAVE_ADDR(SAVE_ADDR), .VEC_BASE(VEC_BASE)
    ) u_mem (
        .cmd       (cmd),
        .pc        (pc_q),
        .hold      (hold_q),
        .chan      (scan_chan),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );
endmodule

// File: rtl/irq_dispatch_seq_chk.sv
module irq_dispatch_seq_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         busy,
    input logic         start,
    input logic         resume,
    input logic         mem_req,
    input logic         mem_we,
    input logic [W-1:0] mem_addr,
    input logic [W-1:0] mem_wdata,
    input logic         mem_ack,
    input logic [W-1:0] pend
);
    assert_hold_req_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    assert_start_single_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    assert_resume_single_R4: assert property (@(posedge clk) disable iff (rst)
        resume |=> !resume);

    assert_ints_off_R7: assert property (@(posedge clk) disable iff (rst)
        start |-> pend[W-1]);

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        start |-> !resume);

    assert_busy_end_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(start || resume));
endmodule

bind irq_dispatch_seq irq_dispatch_seq_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .start     (start),
    .resume    (resume),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .pend      (pend)
);

// File: tb/sim_irq_dispatch_seq.sv
module sim_irq_dispatch_seq;
    localparam int W          = 16;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 1;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic         rst = 1'b1;
    logic         resched_req = 1'b0;
    logic [W-1:0] set_req = '0;
    logic [W-1:0] cur_pc = '0;
    logic         mem_req, mem_we;
    logic [W-1:0] mem_addr, mem_wdata;
    logic [W-1:0] mem_rdata = '0;
    logic         mem_ack = 1'b0;
    logic         busy, resume, start;
    logic [W-1:0] new_pc, pend;

    irq_dispatch_seq u0 (
        .clk(clk), .rst(rst), .resched_req(resched_req), .set_req(set_req),
        .cur_pc(cur_pc), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .resume(resume), .start(start), .new_pc(new_pc), .pend(pend)
    );

    // Memory model with a host load port.
    logic [W-1:0] mem [0:511];
    logic [15:0]  log_addr [0:255];
    logic         log_we [0:255];
    int           acc_cnt = 0;
    int           lat_cnt = 0;
    logic         hw_en = 1'b0;
    logic [8:0]   hw_addr = '0;
    logic [W-1:0] hw_data = '0;

    always @(posedge clk) begin
        if (hw_en) mem[hw_addr] <= hw_data;
        if (mem_ack) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_req && !rst) begin
            if (lat_cnt == LAT) begin
                mem_ack <= 1'b1;
                lat_cnt <= 0;
                if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[8:0]];
                log_addr[acc_cnt % 256] <= mem_addr;
                log_we[acc_cnt % 256]   <= mem_we;
                acc_cnt <= acc_cnt + 1;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            lat_cnt <= 0;
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_wr(input logic [8:0] a, input logic [W-1:0] d);
        hw_en = 1'b1; hw_addr = a; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic set_bits(input logic [W-1:0] v);
        set_req = v;
        @(negedge clk);
        set_req = '0;
    endtask

    function automatic logic [W-1:0] vec_of(input int k);
        return 16'hA000 + 16'(k) * 16'h0011;
    endfunction

    // Results of the last reschedule.
    int           r_cyc;
    bit           r_start, r_resume, r_busy_ok, r_busy_after, r_pulse_after;
    logic [W-1:0] r_pc;
    int           r_base;

    task automatic resched(input logic [W-1:0] pc);
        r_base = acc_cnt;
        cur_pc = pc;
        resched_req = 1'b1;
        @(negedge clk);
        resched_req = 1'b0;
        r_cyc = 1;
        r_busy_ok = 1'b1;
        while (!start && !resume && r_cyc < 2000) begin
            if (!busy) r_busy_ok = 1'b0;
            @(negedge clk);
            r_cyc++;
        end
        r_start = start;
        r_resume = resume;
        if (!busy) r_busy_ok = 1'b0;
        r_pc = new_pc;
        @(negedge clk);
        r_busy_after = busy;
        r_pulse_after = start | resume;
    endtask

    task automatic run_case(input string name, input logic [W-1:0] p,
                            input logic [W-1:0] w, input logic [W-1:0] mask,
                            input logic [W-1:0] pc, input bit do_rst);
        logic [W-1:0] m, a, p_now;
        int k;
        if (do_rst) begin
            do_reset();
            if (p != '0) set_bits(p);
        end
        host_wr(9'o452, w);
        host_wr(9'o453, mask);
        p_now = pend;
        resched(pc);
        chk("R11", {name, " busy held"}, 32'(r_busy_ok), 32'd1);
        chk("R11", {name, " busy drops"}, 32'(r_busy_after), 32'd0);
        chk("R11", {name, " one pulse"}, 32'(r_pulse_after), 32'd0);
        if (p_now == '0 || p_now[W-1]) begin
            chk("R2", {name, " resume"}, 32'(r_resume), 32'd1);
            chk("R2", {name, " no access"}, 32'(acc_cnt - r_base), 32'd0);
            chk("R2", {name, " pend kept"}, 32'(pend), 32'(p_now));
        end else begin
            m = p_now | w;
            a = m & mask;
            chk("R3", {name, " read waiting"}, {15'd0, log_we[r_base % 256], log_addr[r_base % 256]}, {16'd0, 16'o452});
            chk("R3", {name, " read mask"}, {15'd0, log_we[(r_base+1) % 256], log_addr[(r_base+1) % 256]}, {16'd0, 16'o453});
            if (a == '0) begin
                chk("R4", {name, " resume"}, 32'(r_resume), 32'd1);
                chk("R4", {name, " accesses"}, 32'(acc_cnt - r_base), 32'd3);
                chk("R4", {name, " parked word"}, 32'(mem[9'o452]), 32'(m));
                chk("R4", {name, " pend zero"}, 32'(pend), 32'd0);
            end else begin
                k = 0;
                for (int i = W-1; i >= 0; i--) if (a[i]) k = i;
                chk("R8", {name, " start"}, 32'(r_start), 32'd1);
                chk("R8", {name, " new pc"}, 32'(r_pc), 32'(vec_of(k)));
                chk("R8", {name, " accesses"}, 32'(acc_cnt - r_base), 32'd5);
                chk("R5", {name, " pc save"}, {15'd0, log_we[(r_base+2) % 256], log_addr[(r_base+2) % 256]}, {16'd1, 16'o500});
                chk("R5", {name, " saved pc"}, 32'(mem[9'o500]), 32'(pc));
                chk("R6", {name, " vector addr"}, {15'd0, log_we[(r_base+3) % 256], log_addr[(r_base+3) % 256]}, {16'd0, 16'(16'o501 + k)});
                chk("R7", {name, " final write"}, {15'd0, log_we[(r_base+4) % 256], log_addr[(r_base+4) % 256]}, {16'd1, 16'o452});
                chk("R7", {name, " remaining"}, 32'(mem[9'o452]), 32'(m & ~(16'd1 << k)));
                chk("R7", {name, " ints off"}, 32'(pend), 32'h8000);
            end
        end
    endtask

    int cyc0;

    initial begin
        do_reset();
        chk("R1", "reset pend", 32'(pend), 32'd0);
        chk("R1", "reset busy", 32'(busy), 32'd0);
        chk("R1", "reset start", 32'(start), 32'd0);
        chk("R1", "reset resume", 32'(resume), 32'd0);
        chk("R1", "reset mem_req", 32'(mem_req), 32'd0);

        set_bits(16'h0003);
        set_bits(16'h0100);
        chk("R10", "set accumulate", 32'(pend), 32'h0103);

        for (int k = 0; k < W; k++) host_wr(9'(9'o501 + k), vec_of(k));

        run_case("false zero", 16'h0000, 16'h0001, 16'hFFFF, 16'h1234, 1'b1);
        run_case("false off", 16'h8001, 16'h0000, 16'hFFFF, 16'h1234, 1'b1);
        run_case("park", 16'h0004, 16'h0010, 16'h0100, 16'h2222, 1'b1);
        run_case("park empty mask", 16'h0001, 16'h0000, 16'h0000, 16'h2222, 1'b1);

        cyc0 = 0;
        for (int k = 0; k < W-1; k++) begin
            run_case($sformatf("sweep%0d", k), 16'd1 << k, 16'h4000, 16'h7FFF,
                     16'h0400 + 16'(k), 1'b1);
            if (k == 0) cyc0 = r_cyc;
            else chk("R6", $sformatf("scan cost ch%0d", k), 32'(r_cyc - cyc0), 32'(k));
        end

        run_case("masked low", 16'h0003, 16'h0000, 16'hFFFE, 16'h0777, 1'b1);
        run_case("from waiting", 16'h0020, 16'h0008, 16'h0008, 16'h0778, 1'b1);
        run_case("top channel", 16'h0100, 16'h8000, 16'h8000, 16'h0779, 1'b1);
        run_case("while off", 16'h0000, 16'h0001, 16'hFFFF, 16'h077A, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule